// File: doc/BRIEF.md
# Byte-wide flash command interpreter

This block stands in for a byte-wide non-volatile memory that is driven through a command interface. It sits on a simple synchronous memory-mapped bus. Every bus write is treated as a command byte or as the data cycle of a two-cycle command, and never as a direct store. A small state machine decodes the command byte and keeps track of three things: the current read mode, whether a second bus cycle is pending, and a status byte with sticky error flags.

Storage is an internal byte array. Its depth is a parameter, and so is its erase block size, which must be a power of two. A block erase sweeps the block one byte per clock. During the sweep the block raises a busy output and a wait signal. The bus master must hold its access until wait falls, because accesses presented while wait is high are dropped. Read data is registered and appears on the clock after the read strobe.

Top module: `flash_cmd_core`

## Requirements
- R1: Reset (`rst_ni` low) does four things: it selects array read mode, zeroes the status byte, cancels any pending second cycle and sets `rdata_o` to 0x00. It does not touch the array contents. At power-on every array byte is 0xFF.
- R2: In array read mode, a read of an address below `DEPTH` returns the stored byte and a read of any higher address returns 0xFF. Read data appears on `rdata_o` one clock after the accepted read strobe.
- R3: A first-cycle byte of 0xFF selects array read mode, 0x70 selects status read mode, 0x90 selects identifier read mode and 0xB0 selects suspend mode. None of them opens a second cycle, and the first-cycle address is ignored. A read in suspend mode returns 0xFF.
- R4: A first-cycle byte of 0x50 zeroes the status byte and selects array read mode.
- R5: A first-cycle 0x40 or 0x10 arms a byte write. The next write stores its data at its own address if that address is below `DEPTH`. A higher address discards the data. Neither case changes the status byte. Until a new mode command arrives, reads return 0xFF.
- R6: A first-cycle 0x20 arms an erase. A following 0xD0 sets to 0xFF every in-range byte of the block that holds the address of the 0xD0 write, where the block base is that address with its low log2(`BLK_BYTES`) bits cleared. Bytes outside that block keep their values, and reads afterwards return 0xFF until a mode command arrives.
- R7: After 0x20, any second-cycle byte other than 0xD0 selects status read mode and sets status bits 5 (erase error) and 4 (write error). These bits stay set until a 0x50 command or a reset.
- R8: In identifier read mode, an even address returns `DEV_ID[7:0]` and an odd address returns `DEV_ID[15:8]`.
- R9: A first-cycle byte that matches no command leaves the mode unchanged and opens no second cycle. Every second-cycle write ends the sequence.
- R10: An accepted erase confirm raises `busy_o` and `wait_o` from the next clock for exactly `BLK_BYTES` cycles. Reads and writes presented while `wait_o` is high have no effect.
- R11: Reads never change the mode or a pending second cycle.
- R12: In status read mode, bits 7, 6 and 3 to 0 of the returned byte are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 8 | Write data or command byte |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data |
| wait_o | output | 1 | Hold off bus accesses |
| busy_o | output | 1 | Erase sweep in progress |

## Verification
The bench exercises the following corner cases:
- **First-cycle address.** The first cycle is written to one address and the second to another. A design that used the first address would store the byte in the wrong place.
- **Erase block boundaries.** Bytes are planted just outside the erased block. An erase block that runs past the end of the array is also swept. A wrong base mask or an off-by-one sweep length corrupts a neighbour or leaves a byte unerased.
- **Malformed erase.** A bad second byte after 0x20 is tested for its sticky bits and for clearing with 0x50. A design that reset the status instead of OR-ing into it, or that returned to array mode, reads back the wrong byte.
- **Held accesses.** A command is driven while the sweep is busy. Unknown codes, reads between the two cycles, and resets with data in the array complete the set. A design that let any of these through changes the read mode or loses the stored contents.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam logic [7:0] CMD_PROG_ALT  = 8'h10;
  localparam logic [7:0] CMD_ERS_SETUP = 8'h20;
  localparam logic [7:0] CMD_PROG      = 8'h40;
  localparam logic [7:0] CMD_STS_CLR   = 8'h50;
  localparam logic [7:0] CMD_STS_RD    = 8'h70;
  localparam logic [7:0] CMD_ID_RD     = 8'h90;
  localparam logic [7:0] CMD_SUSP      = 8'hB0;
  localparam logic [7:0] CMD_ERS_CONF  = 8'hD0;
  localparam logic [7:0] CMD_ARR_RD    = 8'hFF;

  localparam logic [7:0] STS_ERS_ERR   = 8'h20;
  localparam logic [7:0] STS_PROG_ERR  = 8'h10;
  localparam logic [7:0] ERASED_BYTE   = 8'hFF;

  typedef enum logic [2:0] {
    MODE_ARRAY,
    MODE_STATUS,
    MODE_IDENT,
    MODE_SUSPEND,
    MODE_PROG,
    MODE_ERASE
  } fl_mode_e;
endpackage

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       acc_we_i,
  input  logic [7:0] wdata_i,
  output fl_mode_e   mode_o,
  output logic [7:0] status_o,
  output logic       cyc2_o,
  output logic       prog_en_o,
  output logic       ers_start_o
);
  fl_mode_e   mode_q, mode_d;
  logic [7:0] status_q, status_d;
  logic       cyc2_q, cyc2_d;

  always_comb begin
    mode_d      = mode_q;
    status_d    = status_q;
    cyc2_d      = cyc2_q;
    prog_en_o   = 1'b0;
    ers_start_o = 1'b0;
    if (acc_we_i) begin
      if (!cyc2_q) begin
        unique case (wdata_i)
          CMD_ARR_RD:  mode_d = MODE_ARRAY;
          CMD_STS_RD:  mode_d = MODE_STATUS;
          CMD_ID_RD:   mode_d = MODE_IDENT;
          CMD_SUSP:    mode_d = MODE_SUSPEND;
          CMD_STS_CLR: begin
            status_d = 8'h00;
            mode_d   = MODE_ARRAY;
          end
          CMD_PROG, CMD_PROG_ALT: begin
            mode_d = MODE_PROG;
            cyc2_d = 1'b1;
          end
          CMD_ERS_SETUP: begin
            mode_d = MODE_ERASE;
            cyc2_d = 1'b1;
          end
          default: ;  // unknown code: no effect
        endcase
      end else begin
        cyc2_d = 1'b0;
        if (mode_q == MODE_PROG) begin
          prog_en_o = 1'b1;
        end else if (mode_q == MODE_ERASE) begin
          if (wdata_i == CMD_ERS_CONF) begin
            ers_start_o = 1'b1;
          end else begin
            mode_d   = MODE_STATUS;
            status_d = status_q | STS_ERS_ERR | STS_PROG_ERR;
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_ARRAY;
      status_q <= 8'h00;
      cyc2_q   <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      status_q <= status_d;
      cyc2_q   <= cyc2_d;
    end
  end

  assign mode_o   = mode_q;
  assign status_o = status_q;
  assign cyc2_o   = cyc2_q;
endmodule

// File: rtl/flash_cmd_store.sv
module flash_cmd_store
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DEPTH     = 200,
  parameter int BLK_BYTES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_en_i,
  input  logic              ers_start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rd_data_o,
  output logic              rd_in_range_o,
  output logic              busy_o
);
  localparam int BLK_W = $clog2(BLK_BYTES);
  localparam logic [ADDR_W:0]   LIMIT    = (ADDR_W+1)'(DEPTH);
  localparam logic [ADDR_W-1:0] BLK_MASK = ADDR_W'(BLK_BYTES - 1);
  localparam logic [BLK_W-1:0]  CNT_LAST = BLK_W'(BLK_BYTES - 1);

  logic [7:0]        mem [0:DEPTH-1];
  logic              busy_q;
  logic [BLK_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] sweep_addr;
  logic              sweep_ok, addr_ok;

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = ERASED_BYTE;
  end

  assign addr_ok    = {1'b0, addr_i} < LIMIT;
  assign sweep_addr = base_q | ADDR_W'(cnt_q);
  assign sweep_ok   = {1'b0, sweep_addr} < LIMIT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      base_q <= '0;
    end else if (ers_start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      base_q <= addr_i & ~BLK_MASK;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_LAST) busy_q <= 1'b0;
    end
  end

  // array has no reset: contents survive rst_ni
  always_ff @(posedge clk_i) begin
    if (prog_en_i && addr_ok) mem[addr_i] <= wdata_i;
    if (busy_q && sweep_ok)   mem[sweep_addr] <= ERASED_BYTE;
  end

  assign rd_data_o     = mem[addr_i];
  assign rd_in_range_o = addr_ok;
  assign busy_o        = busy_q;
endmodule

// File: rtl/flash_cmd_rdmux.sv
module flash_cmd_rdmux
  import flash_cmd_pkg::*;
#(
  parameter logic [15:0] DEV_ID = 16'hC3A5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       acc_re_i,
  input  fl_mode_e   mode_i,
  input  logic [7:0] status_i,
  input  logic       addr_lsb_i,
  input  logic [7:0] arr_data_i,
  input  logic       arr_in_range_i,
  output logic [7:0] rdata_o
);
  logic [7:0] sel;

  always_comb begin
    unique case (mode_i)
      MODE_ARRAY:  sel = arr_in_range_i ? arr_data_i : ERASED_BYTE;
      MODE_STATUS: sel = status_i;
      MODE_IDENT:  sel = addr_lsb_i ? DEV_ID[15:8] : DEV_ID[7:0];
      default:     sel = ERASED_BYTE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_o <= 8'h00;
    else if (acc_re_i) rdata_o <= sel;
  end
endmodule

// File: rtl/flash_cmd_core.sv
module flash_cmd_core
  import flash_cmd_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int          DEPTH     = 200,
  parameter int          BLK_BYTES = 16,
  parameter logic [15:0] DEV_ID    = 16'hC3A5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  output logic [7:0]        rdata_o,
  output logic              wait_o,
  output logic              busy_o
);
  fl_mode_e   mode_q;
  logic [7:0] status_q;
  logic       cyc2_q;
  logic       prog_en, ers_start, busy;
  logic       acc_we, acc_re;
  logic [7:0] arr_data;
  logic       arr_in_range;

  assign acc_we = we_i & ~busy;
  assign acc_re = re_i & ~busy;

  flash_cmd_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .acc_we_i    (acc_we),
    .wdata_i     (wdata_i),
    .mode_o      (mode_q),
    .status_o    (status_q),
    .cyc2_o      (cyc2_q),
    .prog_en_o   (prog_en),
    .ers_start_o (ers_start)
  );

  flash_cmd_store #(
    .ADDR_W    (ADDR_W),
    .DEPTH     (DEPTH),
    .BLK_BYTES (BLK_BYTES)
  ) u_store (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .prog_en_i     (prog_en),
    .ers_start_i   (ers_start),
    .addr_i        (addr_i),
    .wdata_i       (wdata_i),
    .rd_data_o     (arr_data),
    .rd_in_range_o (arr_in_range),
    .busy_o        (busy)
  );

  flash_cmd_rdmux #(.DEV_ID(DEV_ID)) u_rdmux (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .acc_re_i       (acc_re),
    .mode_i         (mode_q),
    .status_i       (status_q),
    .addr_lsb_i     (addr_i[0]),
    .arr_data_i     (arr_data),
    .arr_in_range_i (arr_in_range),
    .rdata_o        (rdata_o)
  );

  assign wait_o = busy;
  assign busy_o = busy;
endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk
  import flash_cmd_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       we_i,
  input logic       re_i,
  input logic [7:0] wdata_i,
  input logic       busy_o,
  input fl_mode_e   mode_q,
  input logic [7:0] status_q,
  input logic       cyc2_q,
  input logic       ers_start
);
  logic acc_we, clr_cmd;
  assign acc_we  = we_i && !busy_o;
  assign clr_cmd = acc_we && !cyc2_q && wdata_i == CMD_STS_CLR;

  assert_status_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_cmd |=> (status_q == 8'h00 && mode_q == MODE_ARRAY));

  assert_bad_erase_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_we && cyc2_q && mode_q == MODE_ERASE && wdata_i != CMD_ERS_CONF)
      |=> (status_q[5:4] == 2'b11 && mode_q == MODE_STATUS));

  assert_sticky_err_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q[5] && !clr_cmd) |=> status_q[5]);

  assert_cycle_end_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_we && cyc2_q) |=> !cyc2_q);

  assert_erase_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ers_start |=> busy_o);

  assert_hold_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($stable(mode_q) && $stable(status_q) && $stable(cyc2_q)));

  assert_read_no_effect_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && !we_i) |=> ($stable(mode_q) && $stable(cyc2_q)));

  assert_status_rsvd_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q & 8'hCF) == 8'h00);
endmodule

bind flash_cmd_core flash_cmd_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .we_i      (we_i),
  .re_i      (re_i),
  .wdata_i   (wdata_i),
  .busy_o    (busy_o),
  .mode_q    (mode_q),
  .status_q  (status_q),
  .cyc2_q    (cyc2_q),
  .ers_start (ers_start)
);

// File: tb/flash_cmd_core_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_core_tb_top;
  localparam int          ADDR_W = 8;
  localparam int          BLK    = 16;
  localparam logic [15:0] ID     = 16'hC3A5;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [7:0]        wdata_i = '0;
  logic              we_i = 1'b0, re_i = 1'b0;
  logic [7:0]        rdata_o;
  logic              wait_o, busy_o;

  int   n_chk = 0, n_fail = 0;
  logic rd_fire = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk_i = ~clk_i;

  flash_cmd_core #(.ADDR_W(ADDR_W), .DEPTH(200), .BLK_BYTES(BLK), .DEV_ID(ID)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .we_i(we_i), .re_i(re_i), .rdata_o(rdata_o), .wait_o(wait_o), .busy_o(busy_o)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // monitor: compare each accepted read one clock later
  always @(posedge clk_i) rd_fire <= rst_ni && re_i && !wait_o;
  always @(negedge clk_i) begin
    if (rd_fire) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R2: actual %02h expected none (unexpected read)", rdata_o);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, rdata_o, e);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_i);
    while (wait_o) @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
    @(negedge clk_i);
    while (wait_o) @(negedge clk_i);
    addr_i = a; re_i = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk_i);
    re_i = 1'b0;
  endtask

  task automatic pulse_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 reset rdata", rdata_o, 8'h00);
    check("R1 reset wait", {7'd0, wait_o}, 8'h00);
    rd(8'h50, 8'hFF, "R1 power-on erased");
    rd(8'hD0, 8'hFF, "R2 out of range");

    // first-cycle address ignored; alternate write code
    wr(8'h99, 8'h40); wr(8'h05, 8'h3C);
    rd(8'h05, 8'hFF, "R5 prog mode reads FF");
    wr(8'h00, 8'hFF);
    rd(8'h05, 8'h3C, "R5 byte stored");
    rd(8'h99, 8'hFF, "R3 first-cycle addr ignored");
    wr(8'h00, 8'h10); wr(8'h06, 8'hA7);
    wr(8'h00, 8'h10); wr(8'hC8, 8'h12);  // out of range, discarded
    wr(8'h00, 8'hFF);
    rd(8'h06, 8'hA7, "R5 alt write stored");
    rd(8'hC8, 8'hFF, "R5 out-of-range discarded");
    wr(8'h00, 8'h70);
    rd(8'h33, 8'h00, "R5 no error bits");

    // reads between cycles leave pending cycle
    wr(8'h00, 8'h40);
    rd(8'h05, 8'hFF, "R11 read mid sequence");
    wr(8'h07, 8'h5E);
    wr(8'h00, 8'hFF);
    rd(8'h07, 8'h5E, "R11 pending cycle kept");

    // identifier
    wr(8'h00, 8'h90);
    rd(8'h10, ID[7:0], "R8 id even");
    rd(8'h11, ID[15:8], "R8 id odd");
    wr(8'h00, 8'h33);
    rd(8'h23, ID[15:8], "R9 unknown keeps id mode");
    wr(8'h00, 8'hB0);
    rd(8'h05, 8'hFF, "R3 suspend reads FF");
    wr(8'h00, 8'hFF);
    wr(8'h00, 8'h33);
    wr(8'h00, 8'h70);
    rd(8'h05, 8'h00, "R9 unknown opens no cycle");

    // erase block 0x20..0x2F
    wr(8'h00, 8'h40); wr(8'h1F, 8'h66);
    wr(8'h00, 8'h40); wr(8'h20, 8'h5A);
    wr(8'h00, 8'h40); wr(8'h2F, 8'h11);
    wr(8'h00, 8'h40); wr(8'h30, 8'h77);
    wr(8'h00, 8'h20); wr(8'h27, 8'hD0);
    cnt = 0;
    while (wait_o) begin
      cnt++;
      if (busy_o !== 1'b1) check("R10 busy with wait", {7'd0, busy_o}, 8'h01);
      @(negedge clk_i);
    end
    check("R10 busy length", 8'(cnt), 8'(BLK));
    rd(8'h20, 8'hFF, "R6 erase mode reads FF");
    wr(8'h00, 8'hFF);
    rd(8'h20, 8'hFF, "R6 block start erased");
    rd(8'h2F, 8'hFF, "R6 block end erased");
    rd(8'h1F, 8'h66, "R6 below block kept");
    rd(8'h30, 8'h77, "R6 above block kept");

    // block past end of array; access during busy is dropped
    wr(8'h00, 8'h40); wr(8'hC7, 8'h42);
    wr(8'h00, 8'h20); wr(8'hC5, 8'hD0);
    check("R10 busy after confirm", {7'd0, wait_o}, 8'h01);
    addr_i = 8'h00; wdata_i = 8'h70; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
    rd(8'h00, 8'hFF, "R10 write during busy ignored");
    wr(8'h00, 8'hFF);
    rd(8'hC7, 8'hFF, "R6 partial block erased");

    // malformed erase
    wr(8'h00, 8'h20); wr(8'h44, 8'h40);
    rd(8'h81, 8'h30, "R7 error bits in status mode");
    rd(8'h12, 8'h30, "R12 reserved bits zero");
    wr(8'h00, 8'h40); wr(8'h08, 8'h9D);
    wr(8'h00, 8'h70);
    rd(8'h08, 8'h30, "R7 error sticky");
    wr(8'h00, 8'h50);
    rd(8'h08, 8'h9D, "R4 clear goes to array mode");
    wr(8'h00, 8'h70);
    rd(8'h08, 8'h00, "R4 status cleared");

    // reset keeps array, clears status and mode
    wr(8'h00, 8'h20); wr(8'h00, 8'h00);
    wr(8'h00, 8'h40);
    pulse_reset();
    @(negedge clk_i);
    check("R1 rdata after reset", rdata_o, 8'h00);
    rd(8'h08, 8'h9D, "R1 array kept, array mode");
    wr(8'h09, 8'h70);
    rd(8'h08, 8'h00, "R1 status cleared, cycle cancelled");

    repeat (3) @(negedge clk_i);
    if (exp_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R2: actual %0d pending expected 0", exp_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule